// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block is the architectural register store of a 32-bit processor with sixteen visible registers and seven processor modes. A 4-bit register number is turned into a physical storage slot according to the mode field held in the current status word. The low registers and the program counter have a single shared copy. The stack pointer and link register have a private copy in each exception mode. The fast-interrupt mode also has private copies of registers 8 to 12. System mode works on the user copies.

Two combinational read ports and one clocked write port serve the datapath. The block also keeps the current status word and one saved status word for each exception mode. A single-cycle exception-entry request saves the old status, loads the return address into the target mode's link register and switches the mode. Decode, the ALU and interrupt arbitration sit outside. The caller supplies flags, mode changes and exception requests.

Top module: `rbank_regfile`

## Requirements
- R1: Mode codes are user 10000, fast interrupt 10001, interrupt 10010, supervisor 10011, abort 10111, undefined 11011 and system 11111. Any other code held in the mode field is stored as written but decoded as user mode, for register banking and for saved-status access.
- R2: Registers 0 to 7 and register 15 map to one physical copy in every mode.
- R3: In fast-interrupt mode, registers 8 to 12 map to private copies. All other modes share one other copy of registers 8 to 12.
- R4: Registers 13 and 14 have a private copy in each of the five exception modes. User and system mode share one copy. An unwritten copy reads zero.
- R5: Both read ports are combinational and decode with the current mode. A write lands on the clock edge, using the mode in force before that edge. A read of the same register in the write cycle returns the old value.
- R6: Status word layout: bits 31..28 hold N, Z, C and V. Bit 7 is the interrupt disable and bit 6 is the fast-interrupt disable. Bits 4..0 hold the mode, and all other bits read zero. A flag write replaces bits 31..28 only. A mode write replaces bits 4..0 only.
- R7: Each exception mode has its own saved status word, read and written through one port for the current mode. Only the bits listed in R6 are stored. In user, system or an unknown mode, the port reads the current status word and a write to it is dropped.
- R8: An exception request whose target is an exception mode completes in one cycle. The old current status goes to the target's saved status word. The return address goes to the target's register 14. Only the mode field of the current status changes.
- R9: In an exception-request cycle, register, flag, mode and saved-status writes are all dropped. A request whose target is not an exception mode changes nothing.
- R10: Synchronous active-high reset clears every register and every saved status word. It sets the current status to supervisor mode with both interrupt disables set and the flags clear (word 0x000000D3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_sel | input | 4 | Register number, read port A |
| rd_a_data | output | 32 | Read data, port A |
| rd_b_sel | input | 4 | Register number, read port B |
| rd_b_data | output | 32 | Read data, port B |
| wr_en | input | 1 | Register write enable |
| wr_sel | input | 4 | Register number to write |
| wr_data | input | 32 | Register write data |
| flag_wr_en | input | 1 | Condition flag write enable |
| flag_wr | input | 4 | New N, Z, C, V (bit 3 is N) |
| mode_wr_en | input | 1 | Mode field write enable |
| mode_wr | input | 5 | New mode code |
| spsr_wr_en | input | 1 | Saved status write enable |
| spsr_wr_data | input | 32 | Saved status write data |
| exc_en | input | 1 | Exception entry request |
| exc_mode | input | 5 | Target mode of the exception |
| exc_ret_addr | input | 32 | Return address for the target's register 14 |
| cpsr_o | output | 32 | Current status word |
| spsr_o | output | 32 | Saved status word of the current mode |

## Verification
Exception entry and normal writes can be requested in the same cycle. The bench drives an exception request together with a register write to a shared register, a flag write, a mode write and a saved-status write. It then checks that only the entry's effects show: new mode, old flags, saved old status, and return address in the target link register with the shared register unchanged. A second such cycle uses a non-exception target and checks that nothing at all moved.

// File: rtl/rbank_pkg.sv
package rbank_pkg;

    localparam int SEL_W    = 4;
    localparam int MODE_W   = 5;
    localparam int NFLAG    = 4;
    localparam int NLOW     = 8;                 // shared r0..r7
    localparam int NMID     = 5;                 // r8..r12
    localparam int NBANK    = 6;                 // user/sys + five exception banks
    localparam int NEXC     = NBANK - 1;
    localparam int PC_SLOT  = NLOW;
    localparam int MID_USR  = PC_SLOT + 1;
    localparam int MID_FIQ  = MID_USR + NMID;
    localparam int HI_BASE  = MID_FIQ + NMID;
    localparam int NPHYS    = HI_BASE + 2 * NBANK;
    localparam int PW       = $clog2(NPHYS);

    typedef enum logic [MODE_W-1:0] {
        M_USR = 5'b10000,
        M_FIQ = 5'b10001,
        M_IRQ = 5'b10010,
        M_SVC = 5'b10011,
        M_ABT = 5'b10111,
        M_UND = 5'b11011,
        M_SYS = 5'b11111
    } mode_e;

    typedef struct packed {
        logic              n;
        logic              z;
        logic              c;
        logic              v;
        logic              irq_off;
        logic              fiq_off;
        logic [MODE_W-1:0] mode;
    } psr_t;

    localparam psr_t PSR_RESET = '{n: 1'b0, z: 1'b0, c: 1'b0, v: 1'b0,
                                   irq_off: 1'b1, fiq_off: 1'b1, mode: M_SVC};

    function automatic mode_e norm_mode(input logic [MODE_W-1:0] m);
        case (m)
            M_USR, M_FIQ, M_IRQ, M_SVC, M_ABT, M_UND, M_SYS: return mode_e'(m);
            default: return M_USR;
        endcase
    endfunction

    // 0 = user/system, 1..5 = exception banks
    function automatic logic [2:0] bank_of(input mode_e m);
        case (m)
            M_FIQ:   return 3'd1;
            M_IRQ:   return 3'd2;
            M_SVC:   return 3'd3;
            M_ABT:   return 3'd4;
            M_UND:   return 3'd5;
            default: return 3'd0;
        endcase
    endfunction

    function automatic logic [PW-1:0] phys_idx(input mode_e m, input logic [SEL_W-1:0] sel);
        int s;
        int idx;
        s = int'(sel);
        if (s < NLOW)
            idx = s;
        else if (s == 15)
            idx = PC_SLOT;
        else if (s < NLOW + NMID)
            idx = ((m == M_FIQ) ? MID_FIQ : MID_USR) + (s - NLOW);
        else
            idx = HI_BASE + 2 * int'(bank_of(m)) + (s - 13);
        return PW'(idx);
    endfunction

    function automatic logic [31:0] psr_word(input psr_t p);
        logic [31:0] w;
        w          = '0;
        w[31:28]   = {p.n, p.z, p.c, p.v};
        w[7]       = p.irq_off;
        w[6]       = p.fiq_off;
        w[4:0]     = p.mode;
        return w;
    endfunction

    function automatic psr_t word_psr(input logic [31:0] w);
        psr_t p;
        {p.n, p.z, p.c, p.v} = w[31:28];
        p.irq_off            = w[7];
        p.fiq_off            = w[6];
        p.mode               = w[4:0];
        return p;
    endfunction

endpackage

// File: rtl/rbank_store.sv
module rbank_store #(
    parameter int DW    = 32,
    parameter int DEPTH = 31,
    parameter int NRD   = 2,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr [NRD],
    output logic [DW-1:0] rdata [NRD]
);

    logic [DW-1:0] cell_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) cell_q[i] <= '0;
        end else if (we) begin
            cell_q[waddr] <= wdata;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rdata[p] = cell_q[raddr[p]];
    end

endmodule

// File: rtl/rbank_psr.sv
module rbank_psr
    import rbank_pkg::*;
#(
    parameter int NSAVE = NEXC,
    localparam int SLW  = $clog2(NSAVE)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              exc_req,
    input  logic              exc_fire,
    input  mode_e             exc_tgt,
    input  logic              flag_we,
    input  logic [NFLAG-1:0]  flags,
    input  logic              mode_we,
    input  logic [MODE_W-1:0] mode_in,
    input  logic              save_we,
    input  psr_t              save_in,
    output psr_t              cpsr,
    output psr_t              save_view
);

    psr_t           cur_q;
    psr_t           saved_q [NSAVE];
    logic [2:0]     cur_bank;
    logic [2:0]     tgt_bank;
    logic [SLW-1:0] cur_slot;
    logic [SLW-1:0] tgt_slot;

    always_comb begin
        cur_bank = bank_of(norm_mode(cur_q.mode));
        tgt_bank = bank_of(exc_tgt);
        cur_slot = SLW'(cur_bank - 3'd1);
        tgt_slot = SLW'(tgt_bank - 3'd1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= PSR_RESET;
        end else if (exc_fire) begin
            cur_q.mode <= exc_tgt;
        end else if (!exc_req) begin
            if (flag_we) {cur_q.n, cur_q.z, cur_q.c, cur_q.v} <= flags;
            if (mode_we) cur_q.mode <= mode_in;
        end
    end

    for (genvar s = 0; s < NSAVE; s++) begin : g_save
        always_ff @(posedge clk) begin
            if (rst) begin
                saved_q[s] <= '0;
            end else if (exc_fire) begin
                if (tgt_slot == SLW'(s)) saved_q[s] <= cur_q;
            end else if (!exc_req && save_we && cur_bank != 3'd0) begin
                if (cur_slot == SLW'(s)) saved_q[s] <= save_in;
            end
        end
    end

    always_comb begin
        cpsr      = cur_q;
        save_view = cur_q;
        for (int s = 0; s < NSAVE; s++)
            if (cur_bank != 3'd0 && cur_slot == SLW'(s)) save_view = saved_q[s];
    end

endmodule

// File: rtl/rbank_regfile.sv
module rbank_regfile
    import rbank_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [3:0]    rd_a_sel,
    output logic [DW-1:0] rd_a_data,
    input  logic [3:0]    rd_b_sel,
    output logic [DW-1:0] rd_b_data,
    input  logic          wr_en,
    input  logic [3:0]    wr_sel,
    input  logic [DW-1:0] wr_data,
    input  logic          flag_wr_en,
    input  logic [3:0]    flag_wr,
    input  logic          mode_wr_en,
    input  logic [4:0]    mode_wr,
    input  logic          spsr_wr_en,
    input  logic [31:0]   spsr_wr_data,
    input  logic          exc_en,
    input  logic [4:0]    exc_mode,
    input  logic [DW-1:0] exc_ret_addr,
    output logic [31:0]   cpsr_o,
    output logic [31:0]   spsr_o
);

    localparam int NRD = 2;

    psr_t          cpsr;
    psr_t          save_view;
    mode_e         cur_mode;
    mode_e         tgt_mode;
    logic          exc_fire;
    logic          st_we;
    logic [PW-1:0] st_waddr;
    logic [DW-1:0] st_wdata;
    logic [PW-1:0] st_raddr [NRD];
    logic [DW-1:0] st_rdata [NRD];
    logic [3:0]    rd_sel   [NRD];

    assign rd_sel[0] = rd_a_sel;
    assign rd_sel[1] = rd_b_sel;

    always_comb begin
        cur_mode = norm_mode(cpsr.mode);
        tgt_mode = norm_mode(exc_mode);
        exc_fire = exc_en && (bank_of(tgt_mode) != 3'd0);
        st_we    = exc_fire || (wr_en && !exc_en);
        st_waddr = exc_fire ? phys_idx(tgt_mode, 4'd14) : phys_idx(cur_mode, wr_sel);
        st_wdata = exc_fire ? exc_ret_addr : wr_data;
    end

    for (genvar p = 0; p < NRD; p++) begin : g_map
        assign st_raddr[p] = phys_idx(cur_mode, rd_sel[p]);
    end

    rbank_store #(
        .DW    (DW),
        .DEPTH (NPHYS),
        .NRD   (NRD)
    ) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (st_we),
        .waddr (st_waddr),
        .wdata (st_wdata),
        .raddr (st_raddr),
        .rdata (st_rdata)
    );

    rbank_psr #(
        .NSAVE (NEXC)
    ) u_psr (
        .clk       (clk),
        .rst       (rst),
        .exc_req   (exc_en),
        .exc_fire  (exc_fire),
        .exc_tgt   (tgt_mode),
        .flag_we   (flag_wr_en),
        .flags     (flag_wr),
        .mode_we   (mode_wr_en),
        .mode_in   (mode_wr),
        .save_we   (spsr_wr_en),
        .save_in   (word_psr(spsr_wr_data)),
        .cpsr      (cpsr),
        .save_view (save_view)
    );

    assign rd_a_data = st_rdata[0];
    assign rd_b_data = st_rdata[1];
    assign cpsr_o    = psr_word(cpsr);
    assign spsr_o    = psr_word(save_view);

endmodule

// File: rtl/rbank_chk.sv
module rbank_chk (
    input logic        clk,
    input logic        rst,
    input logic [3:0]  rd_a_sel,
    input logic [31:0] rd_a_data,
    input logic        wr_en,
    input logic [3:0]  wr_sel,
    input logic [31:0] wr_data,
    input logic        flag_wr_en,
    input logic [3:0]  flag_wr,
    input logic        mode_wr_en,
    input logic        exc_en,
    input logic [4:0]  exc_mode,
    input logic [31:0] cpsr_o,
    input logic [31:0] spsr_o
);
    import rbank_pkg::*;

    logic armed;
    logic rst_d;
    logic fire;
    logic cur_plain;

    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    always_ff @(posedge clk) rst_d <= rst;

    always_comb begin
        fire      = exc_en && (bank_of(norm_mode(exc_mode)) != 3'd0);
        cur_plain = (bank_of(norm_mode(cpsr_o[4:0])) == 3'd0);
    end

    // R10: status word right after reset release
    always @(posedge clk) begin
        if (rst_d === 1'b1 && rst === 1'b0)
            p_reset_psr_r10: assert (cpsr_o == 32'h0000_00D3);
    end

    p_exc_entry_r8: assert property (@(posedge clk) disable iff (rst)
        armed && fire |=> (cpsr_o[4:0] == $past(exc_mode)) && (spsr_o == $past(cpsr_o)));

    p_exc_keeps_flags_r9: assert property (@(posedge clk) disable iff (rst)
        armed && exc_en |=> cpsr_o[31:28] == $past(cpsr_o[31:28]));

    p_exc_bad_target_r9: assert property (@(posedge clk) disable iff (rst)
        armed && exc_en && !fire |=> cpsr_o == $past(cpsr_o));

    p_flag_write_r6: assert property (@(posedge clk) disable iff (rst)
        armed && flag_wr_en && !exc_en |=> cpsr_o[31:28] == $past(flag_wr));

    p_write_visible_r5: assert property (@(posedge clk) disable iff (rst)
        armed && wr_en && !exc_en && !mode_wr_en |=>
            (rd_a_sel != $past(wr_sel)) || (rd_a_data == $past(wr_data)));

    p_read_hold_r5: assert property (@(posedge clk) disable iff (rst)
        armed && !wr_en && !exc_en && !mode_wr_en |=>
            (rd_a_sel != $past(rd_a_sel)) || (rd_a_data == $past(rd_a_data)));

    p_plain_saved_r7: assert property (@(posedge clk) disable iff (rst)
        armed && cur_plain |-> spsr_o == cpsr_o);

endmodule

bind rbank_regfile rbank_chk u_chk (.*);

// File: tb/tb_rbank_regfile.sv
`timescale 1ns/1ps
module tb_rbank_regfile;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  rd_a_sel = '0;
    logic [31:0] rd_a_data;
    logic [3:0]  rd_b_sel = '0;
    logic [31:0] rd_b_data;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic        flag_wr_en = 1'b0;
    logic [3:0]  flag_wr = '0;
    logic        mode_wr_en = 1'b0;
    logic [4:0]  mode_wr = '0;
    logic        spsr_wr_en = 1'b0;
    logic [31:0] spsr_wr_data = '0;
    logic        exc_en = 1'b0;
    logic [4:0]  exc_mode = '0;
    logic [31:0] exc_ret_addr = '0;
    logic [31:0] cpsr_o;
    logic [31:0] spsr_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    rbank_regfile dut (.*);

    typedef struct packed {
        logic [4:0]  wm;
        logic [3:0]  ws;
        logic [31:0] wd;
        logic [4:0]  rm;
        logic [3:0]  rs;
        logic [31:0] re;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{5'h10, 4'd0,  32'h0000_00A0, 5'h11, 4'd0,  32'h0000_00A0},
        '{5'h10, 4'd8,  32'h0000_00A8, 5'h1F, 4'd8,  32'h0000_00A8},
        '{5'h11, 4'd8,  32'h0000_00F8, 5'h11, 4'd8,  32'h0000_00F8},
        '{5'h12, 4'd9,  32'h0000_0019, 5'h10, 4'd9,  32'h0000_0019},
        '{5'h10, 4'd13, 32'h0000_00D0, 5'h1F, 4'd13, 32'h0000_00D0},
        '{5'h13, 4'd13, 32'h0000_00D3, 5'h13, 4'd13, 32'h0000_00D3},
        '{5'h12, 4'd13, 32'h0000_00D2, 5'h12, 4'd13, 32'h0000_00D2},
        '{5'h17, 4'd14, 32'h0000_00E7, 5'h17, 4'd14, 32'h0000_00E7},
        '{5'h1B, 4'd14, 32'h0000_00EB, 5'h1B, 4'd14, 32'h0000_00EB},
        '{5'h11, 4'd14, 32'h0000_00E1, 5'h11, 4'd14, 32'h0000_00E1},
        '{5'h1F, 4'd14, 32'h0000_00EF, 5'h10, 4'd14, 32'h0000_00EF},
        '{5'h13, 4'd15, 32'h0000_005C, 5'h1B, 4'd15, 32'h0000_005C},
        '{5'h11, 4'd12, 32'h0000_00FC, 5'h10, 4'd12, 32'h0000_0000},
        '{5'h05, 4'd11, 32'h0000_00BB, 5'h1F, 4'd11, 32'h0000_00BB},
        '{5'h11, 4'd10, 32'h0000_00FA, 5'h11, 4'd11, 32'h0000_0000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic set_mode(input logic [4:0] m);
        mode_wr    = m;
        mode_wr_en = 1'b1;
        step();
        mode_wr_en = 1'b0;
    endtask

    task automatic write_reg(input logic [3:0] s, input logic [31:0] d);
        wr_sel  = s;
        wr_data = d;
        wr_en   = 1'b1;
        step();
        wr_en   = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst = 1'b0;
        #1;
        // R10 reset state
        chk("R10 status after reset", cpsr_o, 32'h0000_00D3);
        chk("R10 saved status after reset", spsr_o, 32'h0000_0000);
        rd_a_sel = 4'd0; rd_b_sel = 4'd13; #1;
        chk("R10 r0 cleared", rd_a_data, 32'h0);
        chk("R10 r13 cleared", rd_b_data, 32'h0);

        // table: writes in several modes, then read back through both ports
        for (int i = 0; i < NV; i++) begin
            set_mode(VEC[i].wm);
            write_reg(VEC[i].ws, VEC[i].wd);
        end
        for (int i = 0; i < NV; i++) begin
            set_mode(VEC[i].rm);
            rd_a_sel = VEC[i].rs;
            rd_b_sel = VEC[i].rs;
            #1;
            chk("R1 R2 R3 R4 table port A", rd_a_data, VEC[i].re);
            chk("R1 R2 R3 R4 table port B", rd_b_data, VEC[i].re);
        end

        // R6 flag and mode write in one cycle
        mode_wr = 5'h10; mode_wr_en = 1'b1;
        flag_wr = 4'hA;  flag_wr_en = 1'b1;
        step();
        mode_wr_en = 1'b0; flag_wr_en = 1'b0;
        chk("R6 status after flag+mode write", cpsr_o, 32'hA000_00D0);
        chk("R7 user saved view equals status", spsr_o, 32'hA000_00D0);

        // R8 R9 exception entry colliding with every normal write
        exc_en = 1'b1; exc_mode = 5'h12; exc_ret_addr = 32'h0000_1234;
        wr_en = 1'b1; wr_sel = 4'd0; wr_data = 32'hDEAD_0000;
        flag_wr_en = 1'b1; flag_wr = 4'h5;
        mode_wr_en = 1'b1; mode_wr = 5'h13;
        spsr_wr_en = 1'b1; spsr_wr_data = 32'hFFFF_FFFF;
        step();
        exc_en = 1'b0; wr_en = 1'b0; flag_wr_en = 1'b0; mode_wr_en = 1'b0; spsr_wr_en = 1'b0;
        rd_a_sel = 4'd14; rd_b_sel = 4'd0; #1;
        chk("R8 R9 status after entry", cpsr_o, 32'hA000_00D2);
        chk("R8 saved old status", spsr_o, 32'hA000_00D0);
        chk("R8 return address in r14", rd_a_data, 32'h0000_1234);
        chk("R9 register write dropped", rd_b_data, 32'h0000_00A0);

        // R5 same-cycle write and read
        wr_en = 1'b1; wr_sel = 4'd1; wr_data = 32'h0000_0077; rd_a_sel = 4'd1; #1;
        chk("R5 read during write is old", rd_a_data, 32'h0);
        step();
        wr_en = 1'b0; #1;
        chk("R5 write visible next cycle", rd_a_data, 32'h0000_0077);

        // R7 saved status write in exception mode keeps only defined bits
        spsr_wr_en = 1'b1; spsr_wr_data = 32'hFFFF_FFFF;
        step();
        spsr_wr_en = 1'b0; #1;
        chk("R7 saved status masked write", spsr_o, 32'hF000_00DF);
        chk("R7 status untouched by saved write", cpsr_o, 32'hA000_00D2);

        // R7 write in user mode dropped
        set_mode(5'h10);
        spsr_wr_en = 1'b1; spsr_wr_data = 32'h0000_0000;
        step();
        spsr_wr_en = 1'b0;
        set_mode(5'h12); #1;
        chk("R7 user saved write dropped", spsr_o, 32'hF000_00DF);

        // R9 exception request with non-exception target
        exc_en = 1'b1; exc_mode = 5'h10; exc_ret_addr = 32'h0000_0999;
        wr_en = 1'b1; wr_sel = 4'd2; wr_data = 32'h0000_0033;
        step();
        exc_en = 1'b0; wr_en = 1'b0;
        rd_a_sel = 4'd2; rd_b_sel = 4'd14; #1;
        chk("R9 bad target leaves status", cpsr_o, 32'hA000_00D2);
        chk("R9 bad target drops write", rd_a_data, 32'h0);
        chk("R9 bad target keeps irq r14", rd_b_data, 32'h0000_1234);
        set_mode(5'h10);
        rd_a_sel = 4'd14; #1;
        chk("R4 R9 user r14 untouched", rd_a_data, 32'h0000_00EF);

        // R1 unknown mode code behaves as user
        set_mode(5'h05);
        rd_a_sel = 4'd13; #1;
        chk("R1 unknown mode reads user r13", rd_a_data, 32'h0000_00D0);
        chk("R1 unknown mode status raw", cpsr_o, 32'hA000_00C5);
        chk("R1 R7 unknown mode saved view", spsr_o, 32'hA000_00C5);

        // R4 untouched banks read zero
        set_mode(5'h17);
        rd_a_sel = 4'd13; #1;
        chk("R4 abort r13 unwritten", rd_a_data, 32'h0);

        // R3 R8 fast-interrupt entry from abort
        exc_en = 1'b1; exc_mode = 5'h11; exc_ret_addr = 32'h0000_4444;
        step();
        exc_en = 1'b0;
        rd_a_sel = 4'd14; rd_b_sel = 4'd8; #1;
        chk("R8 fiq entry status", cpsr_o, 32'hA000_00D1);
        chk("R8 fiq saved status", spsr_o, 32'hA000_00D7);
        chk("R8 fiq r14 return address", rd_a_data, 32'h0000_4444);
        chk("R3 fiq r8 private", rd_b_data, 32'h0000_00F8);
        rd_a_sel = 4'd13; #1;
        chk("R4 fiq r13 unwritten", rd_a_data, 32'h0);

        // R10 reset in mid-run
        rst = 1'b1;
        step();
        rst = 1'b0;
        rd_a_sel = 4'd0; rd_b_sel = 4'd15; #1;
        chk("R10 status after second reset", cpsr_o, 32'h0000_00D3);
        chk("R10 r0 cleared again", rd_a_data, 32'h0);
        chk("R10 pc cleared", rd_b_data, 32'h0);
        chk("R10 supervisor saved cleared", spsr_o, 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule